// File: doc/BRIEF.md
# Fan Fault Supervisor with Timed Restart

This block watches the results of a fan tachometer period counter. Each finished count is compared with a programmable 8-bit high limit. A count above the limit marks the fan as too slow or stalled. Every such failure raises an interrupt and a fan-fail status bit. Both stay set until the processor reads status. Each failure also starts a restart window, during which the PWM pin is forced to full drive. The window is timed in ticks of a slow timebase.

A saturating run counter records consecutive failures. When it reaches the configured run length (five by default), the active-low fault pin asserts. Tach measurement goes on after that, so later failures still raise interrupts. The first passing measurement releases the fault pin and clears the run. A polarity control selects whether full drive appears as a high or a low level on the PWM pin. The block sits between the tach counter and the pin drivers. Register decoding and any thermal loop are outside it.

Top module: `fan_restart_guard`

## Requirements
- R1: A measurement is a failure only when `tachValid` is high and `tachCount` is strictly greater than `tachLimit`. A count equal to the limit passes, so a limit of 0xFE flags only a reading of 0xFF.
- R2: A failure sets `irqOut` and `fanFailStat` high from the next clock. Both hold until a cycle with `statusRead` high and no failure, and they read low from the clock after it.
- R3: A failure loads a restart window of SPIN_TICKS timebase ticks, counted from the next clock. While the window is open the PWM drive is full regardless of `dutyIn`. A failure inside an open window reloads it to the full length. The drive returns to `dutyIn` in the cycle after the last tick.
- R4: With `faultEn` high, `faultPinN` goes low on the clock after the FAIL_RUN-th consecutive failure (FAIL_RUN = 5), and not earlier.
- R5: Failures after the fault pin has asserted still set the interrupt. A failure and a status read in the same cycle leave `irqOut` high.
- R6: A passing measurement resets the consecutive-failure run to zero and releases `faultPinN` from the next clock. It leaves the interrupt untouched, and a new fault needs a fresh run of FAIL_RUN failures.
- R7: With `faultEn` low, `faultPinN` is high at once. Raising `faultEn` again restores the state of the failure run without any clock.
- R8: `pwmPin` equals the drive level (full drive or `dutyIn`) when `pwmInvert` is 1, and its complement when `pwmInvert` is 0. The output is combinational.
- R9: After reset `irqOut` and `fanFailStat` are 0, `faultPinN` is 1, no restart window is open and the failure run is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tachCount | input | 8 | Completed tach period count |
| tachValid | input | 1 | One-cycle strobe: tachCount holds a new result |
| tachLimit | input | 8 | High limit on the count |
| dutyIn | input | 1 | Normal PWM waveform from the duty generator |
| statusRead | input | 1 | Processor status read strobe |
| faultEn | input | 1 | Enable for the fault pin |
| pwmInvert | input | 1 | PWM pin polarity: 1 = pin high for full drive |
| tick | input | 1 | One-cycle timebase pulse for the restart window |
| pwmPin | output | 1 | PWM pin drive |
| irqOut | output | 1 | Interrupt, active high |
| fanFailStat | output | 1 | Fan-fail status bit |
| faultPinN | output | 1 | Fan fault pin, active low |

## Verification
A wrong run counter shows up only at `faultPinN`, and only around the fifth failure or the first pass after a run. The bench therefore checks the pin after every failure in a run, after a pass that breaks a run, and after a rebuilt run. A stuck or early-expiring restart counter shows at `pwmPin` within one tick of the expected expiry. The bench walks the window tick by tick, including a reload in mid-window. A wrong priority between a status read and a failure shows at `irqOut` on the very next clock.

// File: rtl/fan_guard_pkg.sv
package fan_guard_pkg;

  // strobes from the control unit to the datapath
  typedef struct packed {
    logic loadSpin;   // open a full restart window
    logic stepSpin;   // one timebase tick elapsed
    logic bumpRun;    // one more consecutive failure
    logic clearRun;   // passing measurement
  } dpCtl_t;

endpackage

// File: rtl/fan_guard_dp.sv
module fan_guard_dp
  import fan_guard_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int SPIN_TICKS = 2,
  parameter int FAIL_RUN   = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] tachCount,
  input  logic [CNT_W-1:0] tachLimit,
  input  dpCtl_t           ctl,
  output logic             overLimit,
  output logic             spinActive,
  output logic             runFull
);

  localparam int SPIN_W = $clog2(SPIN_TICKS + 1);
  localparam int RUN_W  = $clog2(FAIL_RUN + 1);
  localparam logic [SPIN_W-1:0] SPIN_LOAD = SPIN_W'(SPIN_TICKS);
  localparam logic [RUN_W-1:0]  RUN_TOP   = RUN_W'(FAIL_RUN);

  logic [SPIN_W-1:0] spinCnt;
  logic [RUN_W-1:0]  runCnt;

  assign overLimit = tachCount > tachLimit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      spinCnt <= '0;
    end else if (ctl.loadSpin) begin
      spinCnt <= SPIN_LOAD;
    end else if (ctl.stepSpin && spinCnt != '0) begin
      spinCnt <= spinCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt <= '0;
    end else if (ctl.clearRun) begin
      runCnt <= '0;
    end else if (ctl.bumpRun && runCnt != RUN_TOP) begin
      runCnt <= runCnt + 1'b1;
    end
  end

  assign spinActive = spinCnt != '0;
  assign runFull    = runCnt == RUN_TOP;

endmodule

// File: rtl/fan_guard_ctrl.sv
module fan_guard_ctrl
  import fan_guard_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   tachValid,
  input  logic   overLimit,
  input  logic   statusRead,
  input  logic   tick,
  output dpCtl_t ctl,
  output logic   irqFlag
);

  logic failNow;
  logic passNow;

  assign failNow = tachValid & overLimit;
  assign passNow = tachValid & ~overLimit;

  always_comb begin
    ctl          = '0;
    ctl.loadSpin = failNow;
    ctl.stepSpin = tick;
    ctl.bumpRun  = failNow;
    ctl.clearRun = passNow;
  end

  // a new failure outranks a status read in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqFlag <= 1'b0;
    end else if (failNow) begin
      irqFlag <= 1'b1;
    end else if (statusRead) begin
      irqFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/fan_restart_guard.sv
module fan_restart_guard
  import fan_guard_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int SPIN_TICKS = 2,
  parameter int FAIL_RUN   = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] tachCount,
  input  logic             tachValid,
  input  logic [CNT_W-1:0] tachLimit,
  input  logic             dutyIn,
  input  logic             statusRead,
  input  logic             faultEn,
  input  logic             pwmInvert,
  input  logic             tick,
  output logic             pwmPin,
  output logic             irqOut,
  output logic             fanFailStat,
  output logic             faultPinN
);

  dpCtl_t ctl;
  logic   overLimit;
  logic   spinActive;
  logic   runFull;
  logic   irqFlag;
  logic   driveLvl;

  fan_guard_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .tachValid  (tachValid),
    .overLimit  (overLimit),
    .statusRead (statusRead),
    .tick       (tick),
    .ctl        (ctl),
    .irqFlag    (irqFlag)
  );

  fan_guard_dp #(
    .CNT_W      (CNT_W),
    .SPIN_TICKS (SPIN_TICKS),
    .FAIL_RUN   (FAIL_RUN)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .tachCount  (tachCount),
    .tachLimit  (tachLimit),
    .ctl        (ctl),
    .overLimit  (overLimit),
    .spinActive (spinActive),
    .runFull    (runFull)
  );

  assign driveLvl    = spinActive | dutyIn;
  assign pwmPin      = pwmInvert ? driveLvl : ~driveLvl;
  assign irqOut      = irqFlag;
  assign fanFailStat = irqFlag;
  assign faultPinN   = ~(faultEn & runFull);

endmodule

// File: rtl/fan_guard_chk.sv
module fan_guard_chk #(
  parameter int CNT_W    = 8,
  parameter int FAIL_RUN = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] tachCount,
  input logic             tachValid,
  input logic [CNT_W-1:0] tachLimit,
  input logic             statusRead,
  input logic             faultEn,
  input logic             pwmInvert,
  input logic             pwmPin,
  input logic             irqOut,
  input logic             faultPinN
);

  localparam int RUN_W = $clog2(FAIL_RUN + 1);

  logic             isFail;
  logic [RUN_W-1:0] seenRun;

  assign isFail = tachValid && (tachCount > tachLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seenRun <= '0;
    else if (tachValid && !isFail) seenRun <= '0;
    else if (isFail && seenRun != RUN_W'(FAIL_RUN)) seenRun <= seenRun + 1'b1;
  end

  AST_FAIL_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    isFail |=> irqOut); // R2

  AST_READ_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && !isFail) |=> !irqOut); // R2

  AST_FAIL_FULL_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    isFail |=> (pwmPin == pwmInvert)); // R3

  AST_PASS_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    (tachValid && !isFail) |=> faultPinN); // R6

  AST_RUN_ASSERTS_PIN: assert property (@(posedge clk) disable iff (!rstN)
    (faultEn && seenRun == RUN_W'(FAIL_RUN)) |-> !faultPinN); // R4

  AST_NO_EARLY_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    (seenRun != RUN_W'(FAIL_RUN)) |-> faultPinN); // R4

  AST_FAULT_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !faultEn |-> faultPinN); // R7

endmodule

bind fan_restart_guard fan_guard_chk #(
  .CNT_W    (CNT_W),
  .FAIL_RUN (FAIL_RUN)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .tachCount  (tachCount),
  .tachValid  (tachValid),
  .tachLimit  (tachLimit),
  .statusRead (statusRead),
  .faultEn    (faultEn),
  .pwmInvert  (pwmInvert),
  .pwmPin     (pwmPin),
  .irqOut     (irqOut),
  .faultPinN  (faultPinN)
);

// File: tb/fan_restart_guard_bench.sv
module fan_restart_guard_bench;

  localparam int SPIN = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] tachCount = '0;
  logic       tachValid = 1'b0;
  logic [7:0] tachLimit = 8'h80;
  logic       dutyIn = 1'b0;
  logic       statusRead = 1'b0;
  logic       faultEn = 1'b1;
  logic       pwmInvert = 1'b1;
  logic       tick = 1'b0;
  logic       pwmPin, irqOut, fanFailStat, faultPinN;

  int vectors = 0;
  int misses = 0;
  bit done = 0;

  typedef struct {
    logic  pin;
    logic  irq;
    logic  stat;
    logic  fltN;
    string tag;
  } expItem_t;

  expItem_t expQ[$];

  always #2 clk = ~clk;

  fan_restart_guard #(.SPIN_TICKS(SPIN)) u_fan_restart_guard (
    .clk(clk), .rstN(rstN), .tachCount(tachCount), .tachValid(tachValid),
    .tachLimit(tachLimit), .dutyIn(dutyIn), .statusRead(statusRead),
    .faultEn(faultEn), .pwmInvert(pwmInvert), .tick(tick),
    .pwmPin(pwmPin), .irqOut(irqOut), .fanFailStat(fanFailStat),
    .faultPinN(faultPinN)
  );

  // monitor: compares queued expectations once outputs have settled
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        vectors++;
        if (pwmPin !== e.pin || irqOut !== e.irq || fanFailStat !== e.stat ||
            faultPinN !== e.fltN) begin
          misses++;
          $display("FAIL %s: pin/irq/stat/faultN actual %b%b%b%b expected %b%b%b%b",
                   e.tag, pwmPin, irqOut, fanFailStat, faultPinN,
                   e.pin, e.irq, e.stat, e.fltN);
        end
      end
    end
  end

  task automatic expectNow(input logic pin, input logic irq, input logic stat,
                           input logic fltN, input string tag);
    expItem_t e;
    e.pin = pin; e.irq = irq; e.stat = stat; e.fltN = fltN; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic measure(input logic [7:0] cnt, input logic rd);
    @(negedge clk);
    tachValid = 1'b1; tachCount = cnt; statusRead = rd;
    @(negedge clk);
    tachValid = 1'b0; statusRead = 1'b0;
  endtask

  task automatic readStatus();
    @(negedge clk); statusRead = 1'b1;
    @(negedge clk); statusRead = 1'b0;
  endtask

  task automatic pulseTick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    expectNow(0, 0, 0, 1, "R9 reset state");

    measure(8'h80, 0);
    expectNow(0, 0, 0, 1, "R1 count equal to limit passes");
    measure(8'h81, 0);
    expectNow(1, 1, 1, 1, "R1 R2 R3 limit+1 fails, irq and full drive");
    readStatus();
    expectNow(1, 0, 0, 1, "R2 status read clears irq and bit");
    pulseTick(); pulseTick();
    expectNow(1, 0, 0, 1, "R3 window open before last tick");
    pulseTick();
    expectNow(0, 0, 0, 1, "R3 window closed after last tick");

    @(negedge clk); pwmInvert = 1'b0;
    expectNow(1, 0, 0, 1, "R8 invert 0, duty 0 gives pin high");
    @(negedge clk); dutyIn = 1'b1;
    expectNow(0, 0, 0, 1, "R8 invert 0, duty 1 gives pin low");
    @(negedge clk); pwmInvert = 1'b1;
    expectNow(1, 0, 0, 1, "R8 invert 1, duty 1 gives pin high");
    @(negedge clk); dutyIn = 1'b0;
    expectNow(0, 0, 0, 1, "R8 invert 1, duty 0 gives pin low");

    // run of failures: first one was counted above
    measure(8'h90, 0);
    expectNow(1, 1, 1, 1, "R4 two failures, no fault");
    measure(8'h90, 0);
    measure(8'h90, 0);
    expectNow(1, 1, 1, 1, "R4 four failures, no fault");
    pulseTick(); pulseTick();
    measure(8'h90, 0);
    expectNow(1, 1, 1, 0, "R4 fifth failure asserts fault pin");
    pulseTick(); pulseTick();
    expectNow(1, 1, 1, 0, "R3 reloaded window still open");
    pulseTick();
    expectNow(0, 1, 1, 0, "R3 reloaded window closes");

    readStatus();
    expectNow(0, 0, 0, 0, "R2 read clears irq, fault held");
    measure(8'hFF, 1);
    expectNow(1, 1, 1, 0, "R5 failure beats same-cycle read");

    @(negedge clk); faultEn = 1'b0;
    expectNow(1, 1, 1, 1, "R7 enable low releases pin");
    @(negedge clk); faultEn = 1'b1;
    expectNow(1, 1, 1, 0, "R7 enable high restores pin");

    @(negedge clk); tachLimit = 8'hFE;
    measure(8'hFE, 0);
    expectNow(1, 1, 1, 1, "R6 R1 pass at limit releases fault, irq kept");
    measure(8'hFF, 0); measure(8'hFF, 0); measure(8'hFF, 0); measure(8'hFF, 0);
    expectNow(1, 1, 1, 1, "R6 run restarted, four failures no fault");
    measure(8'hFF, 0);
    expectNow(1, 1, 1, 0, "R1 R4 stall reading completes new run");

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      misses++;
      $display("FAIL watchdog: actual hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule